// File: doc/BRIEF.md
# Byte-Lane External Bus Access Controller

This block sits between an internal requester and a 16-bit external memory bus. It accepts one read or write at a time, given as a byte address, a size (byte or word) and write data. It then runs the bus access. That means driving the address, steering the write data onto the correct byte lane, and asserting the direction and lane-select strobes. It also holds the access for a programmed number of extra cycles and for as long as the memory holds its wait line. When the access ends, the block returns a one-cycle ready pulse together with the read data, placed in the internal byte position.

The bus is big-endian. Even-address bytes travel on the upper half of the data bus and odd-address bytes on the lower half. Two strobe encodings share the same datapath.

- **Split-strobe encoding:** separate active-low read, write, upper-select and lower-select lines.
- **Compact encoding:** an active-low odd-lane strobe, a read/not-write line and address bit 0.

An 8-bit bus option moves all data onto the lower half and splits a word access into two byte beats. A request flagged as hitting the fast region always uses exactly one bus cycle per beat.

The controller's states are:

- **IDLE:** waiting for a request.
- **ACTIVE:** the base cycle plus the stretch cycles.
- **HOLD:** extended by the wait line.
- **DONE:** the ready cycle.
- **FAULT:** a rejected request.

Its transitions are:

- **IDLE→ACTIVE:** an aligned request is accepted.
- **IDLE→FAULT:** a word request arrives at an odd address.
- **ACTIVE→ACTIVE:** stretch count remaining, or the second beat of an 8-bit word.
- **ACTIVE→HOLD:** the count has expired and wait is high, in the normal region.
- **HOLD→HOLD:** wait is still high.
- **ACTIVE/HOLD→DONE:** the beat ends and it is the last beat.
- **DONE→IDLE** and **FAULT→IDLE:** unconditional.

Top module: `xbus_lane_ctrl`

## Requirements
- R1: Read data is returned big-endian. A word read returns the even-address byte in bits 15:8 and the odd-address byte in bits 7:0. A byte read returns the byte in bits 7:0 with bits 15:8 zero. The data is the bus value present in the final cycle of the access.
- R2: Write data is steered onto the bus, and `bus_doe` is high only during write bus cycles.
  - On a 16-bit word write, `bus_dout` equals `req_wdata`.
  - On a 16-bit byte write, `req_wdata[7:0]` goes to `bus_dout[15:8]` for an even address and to `bus_dout[7:0]` for an odd address. The other half is zero.
- R3: In split-strobe mode (`cfg_alt`=0), during a bus cycle:
  - `rd_n` is low for a read and `wr_n` is low for a write.
  - `hi_sel_n` is low when the even byte is transferred and `lo_sel_n` is low when the odd byte is transferred (both for a word).
  - `odd_lane_n` and `dir_rd` stay at 1.
- R4: In compact mode (`cfg_alt`=1), during a bus cycle:
  - `dir_rd` is 1 for a read and 0 for a write.
  - `odd_lane_n` is low when the odd byte is transferred.
  - `bus_addr[0]` carries the byte address bit.
  - `rd_n`, `wr_n`, `hi_sel_n` and `lo_sel_n` stay at 1.
- R5: With `cfg_narrow`=1:
  - `hi_sel_n`, `lo_sel_n` and `odd_lane_n` stay at 1.
  - Data uses only bits 7:0.
  - A word access runs as two beats, the even address first and then address+1.
- R6: A normal-region beat with wait low lasts `cfg_stretch`+1 bus cycles (`cfg_stretch` is 0 to 3).
- R7: After the stretch cycles, `ext_wait` is sampled each cycle. A beat ends in the first cycle at or after its last stretch cycle in which `ext_wait` is low.
- R8: A request with `req_fast`=1 takes exactly one bus cycle per beat, whatever the values of `cfg_stretch` and `ext_wait`.
- R9: A word request at an odd address is rejected. `resp_err` is high for exactly the one cycle after acceptance, and there is no bus cycle and no ready.
- R10: Outside bus cycles and after reset, all the following hold:
  - `bus_active`=0 and `bus_doe`=0.
  - All active-low strobes are 1 and `dir_rd`=1.
  - `resp_ready`=0 and `resp_err`=0.
- R11: `resp_ready` is a single-cycle pulse in the cycle right after the last bus cycle.
- R12: `req_valid` is ignored while an access is in progress. The running access keeps its address, and no further access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_fast | input | 1 | Request targets the one-cycle region |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data (byte in bits 7:0) |
| cfg_alt | input | 1 | 0 = split-strobe, 1 = compact encoding |
| cfg_narrow | input | 1 | 1 = 8-bit bus |
| cfg_stretch | input | SW | Extra bus cycles per beat |
| ext_wait | input | 1 | External wait, active high |
| bus_addr | output | AW | Bus byte address |
| bus_dout | output | DW | Bus write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DW | Bus read data |
| bus_active | output | 1 | High during bus cycles |
| rd_n | output | 1 | Read strobe (split mode) |
| wr_n | output | 1 | Write strobe (split mode) |
| hi_sel_n | output | 1 | Upper lane select (split mode) |
| lo_sel_n | output | 1 | Lower lane select (split mode) |
| odd_lane_n | output | 1 | Odd lane strobe (compact mode) |
| dir_rd | output | 1 | Read/not-write (compact mode) |
| resp_ready | output | 1 | Completion pulse |
| resp_err | output | 1 | Rejected request pulse |
| resp_rdata | output | DW | Read data, valid with resp_ready |

## Verification
Counting from the clock edge that accepts a request, bus cycles occupy cycles 1 through T. T is 1 for fast requests. Otherwise it is the larger of stretch+1 and the wait-high length+1, plus stretch+1 again for an 8-bit word's second beat. The ready pulse and read data are due in cycle T+1, and a fault pulse in cycle 1. The bench computes T before the request and then samples at the falling edge of every cycle. It checks strobes, address and data in cycles 1..T, ready and data in T+1, and idle levels in T+2, so each result is compared in exactly the cycle it is due.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_HOLD,
        ST_DONE,
        ST_FAULT
    } xbus_state_e;

    typedef struct packed {
        logic write;
        logic word;
        logic fast;
        logic alt;
        logic narrow;
    } xbus_attr_t;

endpackage

// File: rtl/xbus_lane_map.sv
module xbus_lane_map #(
    parameter int DW = 16
) (
    input  logic          word,
    input  logic          narrow,
    input  logic          beat,
    input  logic          addr0,
    input  logic [DW-1:0] wdata,
    output logic          use_hi,
    output logic          use_lo,
    output logic [DW-1:0] lane_out
);
    localparam int LW = DW / 2;

    always_comb begin
        use_hi   = !narrow && (word || !addr0);
        use_lo   = !narrow && (word || addr0);
        lane_out = '0;
        if (narrow) begin
            // 8-bit bus: every byte rides the lower lane
            if (word && !beat) begin
                lane_out[LW-1:0] = wdata[DW-1:LW];
            end else begin
                lane_out[LW-1:0] = wdata[LW-1:0];
            end
        end else if (word) begin
            lane_out = wdata;
        end else if (addr0) begin
            lane_out[LW-1:0] = wdata[LW-1:0];
        end else begin
            lane_out[DW-1:LW] = wdata[LW-1:0];
        end
    end

endmodule

// File: rtl/xbus_stretch_timer.sv
module xbus_stretch_timer #(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          bypass,
    input  logic [SW-1:0] stretch,
    input  logic          run,
    output logic          expired
);
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= bypass ? '0 : stretch;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/xbus_read_merge.sv
module xbus_read_merge #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture,
    input  logic          word,
    input  logic          narrow,
    input  logic          beat,
    input  logic          addr0,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata
);
    localparam int LW = DW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clear) begin
            rdata <= '0;
        end else if (capture) begin
            if (narrow) begin
                if (word && !beat) begin
                    rdata[DW-1:LW] <= din[LW-1:0];
                end else begin
                    rdata[LW-1:0] <= din[LW-1:0];
                end
            end else if (word) begin
                rdata <= din;
            end else begin
                rdata <= {{LW{1'b0}}, (addr0 ? din[LW-1:0] : din[DW-1:LW])};
            end
        end
    end

endmodule

// File: rtl/xbus_lane_ctrl.sv
module xbus_lane_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_fast,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          cfg_alt,
    input  logic          cfg_narrow,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          ext_wait,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    output logic          bus_active,
    output logic          rd_n,
    output logic          wr_n,
    output logic          hi_sel_n,
    output logic          lo_sel_n,
    output logic          odd_lane_n,
    output logic          dir_rd,
    output logic          resp_ready,
    output logic          resp_err,
    output logic [DW-1:0] resp_rdata
);

    xbus_state_e   state_q, state_d;
    xbus_attr_t    attr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [SW-1:0] stretch_q;
    logic          beat_q;

    logic          accept, misalign, beat_end, split, next_beat, capture;
    logic          tmr_load, tmr_bypass, tmr_run, expired;
    logic [SW-1:0] tmr_stretch;
    logic          use_hi, use_lo;
    logic [DW-1:0] lane_out;
    logic [AW-1:0] beat_addr;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign misalign  = req_word && req_addr[0];
    assign beat_end  = ((state_q == ST_ACTIVE) && expired && (attr_q.fast || !ext_wait))
                     || ((state_q == ST_HOLD) && !ext_wait);
    assign split     = attr_q.narrow && attr_q.word && !beat_q;
    assign next_beat = beat_end && split;
    assign capture   = beat_end && !attr_q.write;
    assign beat_addr = {addr_q[AW-1:1], addr_q[0] | beat_q};

    assign tmr_load    = (accept && !misalign) || next_beat;
    assign tmr_bypass  = accept ? req_fast : attr_q.fast;
    assign tmr_stretch = accept ? cfg_stretch : stretch_q;
    assign tmr_run     = (state_q == ST_ACTIVE);

    xbus_stretch_timer #(.SW(SW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .bypass  (tmr_bypass),
        .stretch (tmr_stretch),
        .run     (tmr_run),
        .expired (expired)
    );

    xbus_lane_map #(.DW(DW)) u_lanes (
        .word     (attr_q.word),
        .narrow   (attr_q.narrow),
        .beat     (beat_q),
        .addr0    (beat_addr[0]),
        .wdata    (wdata_q),
        .use_hi   (use_hi),
        .use_lo   (use_lo),
        .lane_out (lane_out)
    );

    xbus_read_merge #(.DW(DW)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture),
        .word    (attr_q.word),
        .narrow  (attr_q.narrow),
        .beat    (beat_q),
        .addr0   (beat_addr[0]),
        .din     (bus_din),
        .rdata   (resp_rdata)
    );

    // request capture and beat tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr_q    <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            stretch_q <= '0;
            beat_q    <= 1'b0;
        end else if (accept) begin
            attr_q.write  <= req_write;
            attr_q.word   <= req_word;
            attr_q.fast   <= req_fast;
            attr_q.alt    <= cfg_alt;
            attr_q.narrow <= cfg_narrow;
            addr_q        <= req_addr;
            wdata_q       <= req_wdata;
            stretch_q     <= cfg_stretch;
            beat_q        <= 1'b0;
        end else if (next_beat) begin
            beat_q <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = misalign ? ST_FAULT : ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (!expired) begin
                    state_d = ST_ACTIVE;
                end else if (!attr_q.fast && ext_wait) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = split ? ST_ACTIVE : ST_DONE;
                end
            end
            ST_HOLD: begin
                if (!ext_wait) begin
                    state_d = split ? ST_ACTIVE : ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_addr   = beat_addr;
        bus_dout   = '0;
        bus_doe    = 1'b0;
        bus_active = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        hi_sel_n   = 1'b1;
        lo_sel_n   = 1'b1;
        odd_lane_n = 1'b1;
        dir_rd     = 1'b1;
        resp_ready = 1'b0;
        resp_err   = 1'b0;
        unique case (state_q)
            ST_ACTIVE, ST_HOLD: begin
                bus_active = 1'b1;
                bus_doe    = attr_q.write;
                bus_dout   = attr_q.write ? lane_out : '0;
                if (attr_q.alt) begin
                    odd_lane_n = !use_lo;
                    dir_rd     = !attr_q.write;
                end else begin
                    rd_n     = attr_q.write;
                    wr_n     = !attr_q.write;
                    hi_sel_n = !use_hi;
                    lo_sel_n = !use_lo;
                end
            end
            ST_DONE:  resp_ready = 1'b1;
            ST_FAULT: resp_err   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/xbus_lane_ctrl_chk.sv
module xbus_lane_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_active,
    input logic bus_doe,
    input logic rd_n,
    input logic wr_n,
    input logic hi_sel_n,
    input logic lo_sel_n,
    input logic odd_lane_n,
    input logic dir_rd,
    input logic resp_ready,
    input logic resp_err
);

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> !bus_active && !resp_ready); // R9

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |=> !resp_err); // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |=> !resp_ready); // R11

    AST_READY_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ready |-> !bus_active && $past(bus_active)); // R11

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> rd_n && wr_n && hi_sel_n && lo_sel_n && odd_lane_n && dir_rd && !bus_doe); // R10

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3

    AST_ENCODING_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> (rd_n && wr_n && hi_sel_n && lo_sel_n) || (odd_lane_n && dir_rd)); // R4

    AST_DOE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!wr_n || !dir_rd)); // R2

endmodule

bind xbus_lane_ctrl xbus_lane_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_active (bus_active),
    .bus_doe    (bus_doe),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .hi_sel_n   (hi_sel_n),
    .lo_sel_n   (lo_sel_n),
    .odd_lane_n (odd_lane_n),
    .dir_rd     (dir_rd),
    .resp_ready (resp_ready),
    .resp_err   (resp_err)
);

// File: tb/xbus_lane_ctrl_test.sv
`timescale 1ns/1ps
module xbus_lane_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_fast = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        cfg_alt = 1'b0, cfg_narrow = 1'b0;
    logic [1:0]  cfg_stretch = '0;
    logic        ext_wait = 1'b0;
    logic [15:0] bus_addr, bus_dout, bus_din, resp_rdata;
    logic        bus_doe, bus_active, rd_n, wr_n, hi_sel_n, lo_sel_n, odd_lane_n, dir_rd;
    logic        resp_ready, resp_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // memory model on the bus
    assign bus_din = cfg_narrow ? {8'hEE, pat(bus_addr)}
                                : {pat({bus_addr[15:1], 1'b0}), pat({bus_addr[15:1], 1'b1})};

    xbus_lane_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] exp_vec(input bit wr, input bit wd, input bit alt,
                                           input bit nar, input bit a0);
        bit hi, lo;
        hi = !nar && (wd || !a0);
        lo = !nar && (wd || a0);
        if (alt) return {4'b1111, !lo, !wr, wr};
        else     return {wr, !wr, !hi, !lo, 2'b11, wr};
    endfunction

    function automatic logic [6:0] act_vec();
        return {rd_n, wr_n, hi_sel_n, lo_sel_n, odd_lane_n, dir_rd, bus_doe};
    endfunction

    task automatic idle_chk(input string tag);
        chk(!bus_active && !resp_ready && !resp_err && act_vec() == 7'b1111110,
            tag, {bus_active, resp_ready, resp_err, act_vec()}, {3'b000, 7'b1111110});
    endtask

    task automatic run_txn(input bit wr, input bit wd, input bit fast, input bit alt,
                           input bit nar, input logic [1:0] s, input int x,
                           input logic [15:0] a, input logic [15:0] wdat, input bit poke);
        int c1, total;
        logic [15:0] ba, edout, erd;
        string stb;
        c1 = fast ? 1 : ((x + 1 > s + 1) ? x + 1 : s + 1);
        total = (nar && wd) ? (fast ? 2 : c1 + s + 1) : c1;
        stb = alt ? "R4" : "R3";
        @(negedge clk);
        cfg_alt = alt; cfg_narrow = nar; cfg_stretch = s;
        req_write = wr; req_word = wd; req_fast = fast; req_addr = a; req_wdata = wdat;
        req_valid = 1'b1; ext_wait = 1'b0;
        for (int c = 1; c <= total + 2; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (poke && c == 2) begin req_valid = 1'b1; req_addr = a ^ 16'h0F0E; end
            if (c == 3) req_valid = 1'b0;
            ba = (nar && wd && c > (fast ? 1 : c1)) ? (a | 16'h1) : a;
            if (c <= total) begin
                // R6 R7 R8 length; R12 address kept
                chk(bus_active && !resp_ready, "R6/R7/R8 bus cycle", {bus_active, resp_ready}, 2'b10);
                chk(bus_addr == ba, poke ? "R12 addr" : "R5 addr", bus_addr, ba);
                chk(act_vec() == exp_vec(wr, wd, alt, nar, ba[0]),
                    nar ? "R5 strobes" : stb, act_vec(), exp_vec(wr, wd, alt, nar, ba[0]));
                if (wr) begin
                    if (nar) edout = {8'h00, (wd && ba == a) ? wdat[15:8] : wdat[7:0]};
                    else if (wd) edout = wdat;
                    else if (a[0]) edout = {8'h00, wdat[7:0]};
                    else edout = {wdat[7:0], 8'h00};
                    chk(bus_dout == edout, "R2 dout", bus_dout, edout);
                end
            end else if (c == total + 1) begin
                chk(!bus_active && resp_ready && !resp_err, "R11 ready",
                    {bus_active, resp_ready, resp_err}, 3'b010);
                if (!wr) begin
                    erd = wd ? {pat(a), pat(a | 16'h1)} : {8'h00, pat(a)};
                    chk(resp_rdata == erd, "R1 rdata", resp_rdata, erd);
                end
            end else begin
                idle_chk("R10/R12 idle after");
            end
            ext_wait = (c <= x);
        end
        ext_wait = 1'b0;
    endtask

    task automatic run_misaligned(input logic [15:0] a);
        @(negedge clk);
        req_write = 1'b0; req_word = 1'b1; req_fast = 1'b0; req_addr = a | 16'h1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_err && !resp_ready && !bus_active, "R9 fault cycle",
            {resp_err, resp_ready, bus_active}, 3'b100);
        @(negedge clk);
        idle_chk("R9 fault ends");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R10 reset state");
        // directed corners
        run_txn(0, 1, 0, 0, 0, 2'd0, 0, 16'h1230, 16'h0, 0);   // R1 word read, split
        run_txn(1, 0, 0, 0, 0, 2'd1, 0, 16'h2001, 16'h00A7, 0); // R2 odd byte write
        run_txn(1, 0, 0, 1, 0, 2'd0, 0, 16'h2002, 16'h0058, 0); // R4 even byte compact
        run_txn(0, 1, 0, 0, 0, 2'd3, 0, 16'h4444, 16'h0, 0);   // R6 max stretch
        run_txn(0, 0, 0, 0, 0, 2'd3, 6, 16'h5555, 16'h0, 0);   // R7 wait beyond stretch
        run_txn(0, 0, 0, 0, 0, 2'd1, 1, 16'h5556, 16'h0, 0);   // R7 wait inside stretch
        run_txn(0, 1, 1, 0, 0, 2'd3, 5, 16'h6660, 16'h0, 0);   // R8 fast ignores both
        run_txn(1, 1, 0, 1, 1, 2'd2, 3, 16'h7770, 16'hBEEF, 0); // R5 narrow word write
        run_txn(0, 1, 1, 0, 1, 2'd3, 4, 16'h7772, 16'h0, 0);   // R5 R8 narrow fast read
        run_txn(0, 1, 0, 0, 0, 2'd2, 2, 16'h8880, 16'h0, 1);   // R12 poke while busy
        run_misaligned(16'h9990);                               // R9
        // random mix
        for (int i = 0; i < 160; i++) begin
            bit wr, wd, fast, alt, nar;
            logic [15:0] a;
            wr = $urandom % 2; wd = $urandom % 2; fast = ($urandom % 4) == 0;
            alt = $urandom % 2; nar = ($urandom % 3) == 0;
            a = 16'($urandom);
            if (($urandom % 12) == 0) run_misaligned(a);
            else run_txn(wr, wd, fast, alt, nar, 2'($urandom % 4), int'($urandom % 5),
                         wd ? (a & 16'hFFFE) : a, 16'($urandom), ($urandom % 8) == 0);
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule